// File: doc/BRIEF.md
# Dual-Read Integer Register Bank with Hardwired Zero

This block is the integer general-purpose register storage of a simple load/store processor datapath. It holds thirty-two 32-bit words. Two operand fetch ports, each given a 5-bit register id, deliver the addressed word combinationally in the same cycle. A single result port writes one word on the rising clock edge while its enable is high.

Entry 0 is a constant zero source. Reads of id 0 always return zero, and any write aimed at id 0 is thrown away. Both reads and the write may happen in the same cycle. A read of the register being written in that cycle still sees the stored (old) word. The new word becomes visible once the clock edge has passed. A synchronous active-high reset clears every entry.

Top module: `gpr_bank`

## Requirements
- R1: A read port driven with id N (1 to 31) returns the 32-bit word last committed to register N, combinationally and without waiting for a clock edge.
- R2: The two read ports are independent: any pair of ids, including the same id on both, returns the correct word on each port in the same cycle.
- R3: With `wr_en` = 1 and `wr_id` = N (N not 0), `wr_data` is stored into register N at the rising clock edge.
- R4: With `wr_en` = 0, no register changes at the clock edge, whatever `wr_id` and `wr_data` carry.
- R5: Reading id 0 on either port always returns 32'h0000_0000.
- R6: A write with `wr_id` = 0 is discarded: id 0 still reads zero afterwards, and no other register changes.
- R7: When a read id equals the id being written in the same cycle, the read returns the old stored word before the edge and the new word after it.
- R8: With `rst` = 1 at a rising edge, every register reads zero afterwards.
- R9: A write updates only the addressed register; all other registers keep their words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rd_a_id | input | 5 | Register id for read port A |
| rd_a_data | output | 32 | Contents of the register selected by `rd_a_id` |
| rd_b_id | input | 5 | Register id for read port B |
| rd_b_data | output | 32 | Contents of the register selected by `rd_b_id` |
| wr_en | input | 1 | Write enable for the result port |
| wr_id | input | 5 | Register id for the write |
| wr_data | input | 32 | Word to store |

## Verification
The bench builds the bank with its default parameters: a 32-bit word and a 5-bit id, which gives 32 entries. This is small enough that directed sweeps can cover every id on both ports after reset and after each isolated write. The 5-bit id also makes random traffic hit collisions often. Roughly one cycle in 32 brings a read onto the write target, and roughly one in 32 aims a write at the zero entry. Same-cycle read-over-write and discarded zero writes therefore occur many times during the random phase, in addition to the directed cases.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Default geometry of the integer register bank.
    localparam int unsigned GPR_DATA_W = 32;
    localparam int unsigned GPR_ID_W   = 5;
    localparam int unsigned GPR_COUNT  = 1 << GPR_ID_W;

    typedef logic [GPR_DATA_W-1:0] gpr_word_t;
    typedef logic [GPR_ID_W-1:0]   gpr_id_t;

    // One write request on the result port.
    typedef struct packed {
        logic      en;
        gpr_id_t   id;
        gpr_word_t data;
    } gpr_wr_req_t;

    // The zero entry never accepts a write.
    function automatic logic gpr_is_zero_id(input gpr_id_t id);
        return (id == '0);
    endfunction

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
    import gpr_pkg::*;
#(
    parameter int unsigned ID_W  = GPR_ID_W,
    parameter int unsigned COUNT = 1 << ID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  gpr_wr_req_t      req,
    output logic [COUNT-1:0] strobe
);

    // One strobe per entry; the zero entry never gets one.
    for (genvar i = 0; i < COUNT; i++) begin : g_strobe
        if (i == 0) begin : g_zero
            assign strobe[i] = 1'b0;
        end else begin : g_live
            assign strobe[i] = req.en && !gpr_is_zero_id(req.id)
                               && (req.id == ID_W'(i));
        end
    end

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe)); // R9

    AST_DISABLED_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !req.en |-> (strobe == '0)); // R4

endmodule

// File: rtl/gpr_cell_array.sv
module gpr_cell_array
    import gpr_pkg::*;
#(
    parameter int unsigned DATA_W = GPR_DATA_W,
    parameter int unsigned COUNT  = GPR_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COUNT-1:0]  strobe,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cells [COUNT]
);

    for (genvar i = 0; i < COUNT; i++) begin : g_cell
        if (i == 0) begin : g_const
            assign cells[i] = '0;

            AST_ZERO_NEVER_STROBED: assert property (@(posedge clk) disable iff (rst)
                !strobe[i]); // R6
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    cells[i] <= '0;
                end else if (strobe[i]) begin
                    cells[i] <= wdata;
                end
            end

            AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(strobe[i])) |-> $stable(cells[i])); // R4

            AST_CELL_LOAD: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(strobe[i])) |-> (cells[i] == $past(wdata))); // R3
        end
    end

endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
    import gpr_pkg::*;
#(
    parameter int unsigned DATA_W = GPR_DATA_W,
    parameter int unsigned ID_W   = GPR_ID_W,
    parameter int unsigned COUNT  = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] cells [COUNT],
    input  logic [ID_W-1:0]   id,
    output logic [DATA_W-1:0] data
);

    always_comb begin
        data = cells[id];
    end

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
        (id == '0) |-> (data == '0)); // R5

    AST_CLEARED_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (data == '0)); // R8

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int unsigned DATA_W = GPR_DATA_W,
    parameter int unsigned ID_W   = GPR_ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int unsigned COUNT   = 1 << ID_W;
    localparam int unsigned N_READS = 2;

    gpr_wr_req_t       wr_req;
    logic [COUNT-1:0]  strobe;
    logic [DATA_W-1:0] cells [COUNT];
    logic [ID_W-1:0]   rd_ids  [N_READS];
    logic [DATA_W-1:0] rd_words[N_READS];

    always_comb begin
        wr_req.en   = wr_en;
        wr_req.id   = wr_id;
        wr_req.data = wr_data;
    end

    assign rd_ids[0] = rd_a_id;
    assign rd_ids[1] = rd_b_id;
    assign rd_a_data = rd_words[0];
    assign rd_b_data = rd_words[1];

    gpr_wr_decode #(
        .ID_W  (ID_W),
        .COUNT (COUNT)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .req    (wr_req),
        .strobe (strobe)
    );

    gpr_cell_array #(
        .DATA_W (DATA_W),
        .COUNT  (COUNT)
    ) u_cells (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .wdata  (wr_req.data),
        .cells  (cells)
    );

    for (genvar p = 0; p < N_READS; p++) begin : g_rd
        gpr_rd_port #(
            .DATA_W (DATA_W),
            .ID_W   (ID_W),
            .COUNT  (COUNT)
        ) u_port (
            .clk   (clk),
            .rst   (rst),
            .cells (cells),
            .id    (rd_ids[p]),
            .data  (rd_words[p])
        );
    end

    AST_PORT_A_SEES_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && ($past(wr_id) != '0) && (rd_a_id == $past(wr_id)))
        |-> (rd_a_data == $past(wr_data))); // R3

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data)); // R2

    AST_READ_OLD_IN_WRITE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && wr_en && (rd_b_id == wr_id) && $stable(rd_b_id))
        |-> $stable(rd_b_data)); // R7

endmodule

// File: tb/test_gpr_bank.sv
`timescale 1ns/1ps
module test_gpr_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_id, rd_b_id, wr_id;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          done   = 1'b0;
    logic [31:0] mdl [32];

    always #4 clk = ~clk;

    gpr_bank i_gpr_bank (
        .clk       (clk),
        .rst       (rst),
        .rd_a_id   (rd_a_id),
        .rd_a_data (rd_a_data),
        .rd_b_id   (rd_b_id),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_id     (wr_id),
        .wr_data   (wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string auto_tag(input logic [4:0] rid, input logic we,
                                       input logic [4:0] wid, input string dflt);
        if (rid == 5'd0) return "R5";
        if (we && wid == rid) return "R7";
        return dflt;
    endfunction

    // One cycle: drive at negedge, compare against the model, then commit the model.
    task automatic cycle(input logic r, input logic we, input logic [4:0] wid,
                         input logic [31:0] wd, input logic [4:0] ra,
                         input logic [4:0] rb, input string tag);
        @(negedge clk);
        rst = r; wr_en = we; wr_id = wid; wr_data = wd;
        rd_a_id = ra; rd_b_id = rb;
        #1;
        if (!r) begin
            chk(auto_tag(ra, we, wid, tag), rd_a_data, (ra == 0) ? 32'h0 : mdl[ra]);
            chk(auto_tag(rb, we, wid, tag), rd_b_data, (rb == 0) ? 32'h0 : mdl[rb]);
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
        end else if (we && wid != 5'd0) begin
            mdl[wid] = wd;
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 32; i++) begin
            cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i), tag);
            // expected zero check independent of model for the reset sweep
            if (tag == "R8") chk("R8", rd_a_data, 32'h0);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
        rst = 1'b1; wr_en = 1'b0; wr_id = '0; wr_data = '0; rd_a_id = '0; rd_b_id = '0;
        cycle(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R8");
        cycle(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R8");
        sweep("R8");

        // R3 / R1: fill every register with a distinct pattern, then read back.
        for (int i = 1; i < 32; i++)
            cycle(1'b0, 1'b1, 5'(i), 32'hA5A5_0000 ^ (i * 32'h0101_0103), 5'd0, 5'd0, "R3");
        sweep("R1");

        // R2: both ports on the same id and on different ids.
        for (int i = 1; i < 32; i++)
            cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'(i), 5'(i), "R2");
        cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'd7, 5'd19, "R2");

        // R6: write to id 0 is discarded.
        cycle(1'b0, 1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, "R6");
        cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R6");
        chk("R6", rd_a_data, 32'h0);
        sweep("R6");

        // R4: disabled write with live id and data changes nothing.
        cycle(1'b0, 1'b0, 5'd5, 32'h1234_5678, 5'd5, 5'd6, "R4");
        cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'd5, 5'd5, "R4");
        sweep("R4");

        // R7: read of the write target shows old word, then new word.
        cycle(1'b0, 1'b1, 5'd9, 32'hCAFE_F00D, 5'd9, 5'd9, "R7");
        cycle(1'b0, 1'b0, 5'd0, 32'h0, 5'd9, 5'd9, "R7");
        chk("R7", rd_a_data, 32'hCAFE_F00D);

        // R9: one write touches only its target.
        cycle(1'b0, 1'b1, 5'd17, 32'h0F0F_F0F0, 5'd1, 5'd2, "R9");
        sweep("R9");

        // Random traffic covering all requirements against the model.
        for (int n = 0; n < 1500; n++)
            cycle(1'b0, 1'($urandom), 5'($urandom), $urandom, 5'($urandom), 5'($urandom), "R1");

        // R8: reset in mid-run clears everything.
        cycle(1'b1, 1'b1, 5'd3, 32'hFFFF_FFFF, 5'd0, 5'd0, "R8");
        sweep("R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule